// File: doc/BRIEF.md
# Timer Channel Interrupt Status

This block keeps the interrupt status of one channel of a 16-bit timer. The channel has two compare units and two capture units. Each unit signals its event with a single-cycle pulse. The block turns those pulses into sticky status bits.

A capture that lands while the previous capture of the same unit has not yet been serviced is recorded as a separate overwrite condition. Software reaches the status through a small synchronous register port. It reads the flags without side effects and clears them by writing 1 to the bits concerned.

A second register holds one enable bit per flag. The single interrupt request is raised whenever an enabled flag is set.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset all six flags and all six enable bits are 0, and `irq` is 0.
- R2: The flag register is at address 0. Its bit positions are fixed: compare A is bit 0, compare B is bit 1, capture A is bit 2, capture B is bit 3, capture A overwrite is bit 4 and capture B overwrite is bit 5. Read data follows the current state in the same cycle, with no clock delay.
- R3: Bits 15 to 6 of every register read back as 0. Writing those bits has no effect.
- R4: A pulse on `cmp_a_hit` or `cmp_b_hit` sets flag bit 0 or 1. The flag is visible from the clock edge at which the pulse is sampled.
- R5: A pulse on `cap_a_load` or `cap_b_load` sets flag bit 2 or 3 at the sampling edge.
- R6: A capture pulse sets its overwrite flag (bit 4 for A, bit 5 for B) when the matching capture flag was already 1 before that edge. The capture flag stays 1. This also holds when software clears that capture flag in the same cycle.
- R7: A write to address 0 clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R8: When a hardware set and a software clear reach the same flag in the same cycle, the flag ends up 1.
- R9: The enable register is at address 1. Bits 5 to 0 are written directly from the write data, and each enable bit matches the flag in the same position.
- R10: `irq` is 1 exactly when some flag and its enable bit are both 1.
- R11: Reads change no state. Addresses 2 and 3 read as 0, and writes to them change neither flags nor enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_a_hit | input | 1 | Compare A match pulse |
| cmp_b_hit | input | 1 | Compare B match pulse |
| cap_a_load | input | 1 | Capture A load pulse |
| cap_b_load | input | 1 | Capture B load pulse |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardware set path and the software write-1 clear can hit the same flag in one cycle. A capture pulse can also arrive in the same cycle that software clears that capture's flag. Directed steps provoke both cases on purpose. A seeded random phase then produces them many more times by pulsing events while also writing random clear masks.

Each outcome is judged against a bench model in which the set has priority. In that model, the overwrite condition looks at the capture flag as it stood before the edge.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;
  localparam int NFLAG  = 6;
  localparam int NCAP   = 2;

  localparam int BIT_CMP_A = 0;
  localparam int BIT_CMP_B = 1;
  localparam int BIT_CAP_A = 2;
  localparam int BIT_CAP_B = 3;
  localparam int BIT_OVW_A = 4;
  localparam int BIT_OVW_B = 5;

  localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd1;

  // Request is pending when any flag meets its enable.
  function automatic logic any_pending(input logic [NFLAG-1:0] flags,
                                       input logic [NFLAG-1:0] en);
    return |(flags & en);
  endfunction

  // A capture overwrites when its flag is still held.
  function automatic logic [NCAP-1:0] overwrite_of(input logic [NCAP-1:0] evt,
                                                   input logic [NCAP-1:0] held);
    return evt & held;
  endfunction
endpackage

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);                                         // R8
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);                            // R7
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(flag_o));                   // R7
endmodule

// File: rtl/tmr_ovw_detect.sv
module tmr_ovw_detect
  import tmr_irq_pkg::*;
#(
  parameter int N = NCAP
) (
  input  logic [N-1:0] cap_evt_i,
  input  logic [N-1:0] cap_flag_i,
  output logic [N-1:0] ovw_evt_o
);
  for (genvar i = 0; i < N; i++) begin : g_ovw
    logic [N-1:0] one_hot;
    always_comb begin
      one_hot    = '0;
      one_hot[i] = 1'b1;
    end
    assign ovw_evt_o[i] = |overwrite_of(cap_evt_i & one_hot, cap_flag_i & one_hot);
  end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_irq_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_a_hit,
  input  logic          cmp_b_hit,
  input  logic          cap_a_load,
  input  logic          cap_b_load,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int PAD_W = DW - NFLAG;

  logic [NFLAG-1:0] flags_q;
  logic [NFLAG-1:0] en_q;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] clr_vec;
  logic [NCAP-1:0]  ovw_evt;
  logic             wr_flags;
  logic             wr_enable;
  logic             wdata_unused;

  assign wr_flags     = bus_we && (bus_addr == AW'(ADDR_FLAGS));
  assign wr_enable    = bus_we && (bus_addr == AW'(ADDR_ENABLE));
  assign wdata_unused = ^bus_wdata[DW-1:NFLAG];

  tmr_ovw_detect #(.N(NCAP)) u_ovw (
    .cap_evt_i  ({cap_b_load, cap_a_load}),
    .cap_flag_i (flags_q[BIT_CAP_B:BIT_CAP_A]),
    .ovw_evt_o  (ovw_evt)
  );

  always_comb begin
    set_vec                       = '0;
    set_vec[BIT_CMP_A]            = cmp_a_hit;
    set_vec[BIT_CMP_B]            = cmp_b_hit;
    set_vec[BIT_CAP_A]            = cap_a_load;
    set_vec[BIT_CAP_B]            = cap_b_load;
    set_vec[BIT_OVW_B:BIT_OVW_A]  = ovw_evt;
    clr_vec = wr_flags ? bus_wdata[NFLAG-1:0] : '0;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    tmr_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .flag_o (flags_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         en_q <= '0;
    else if (wr_enable) en_q <= bus_wdata[NFLAG-1:0];
  end

  always_comb begin
    if (bus_addr == AW'(ADDR_FLAGS))       bus_rdata = {{PAD_W{1'b0}}, flags_q};
    else if (bus_addr == AW'(ADDR_ENABLE)) bus_rdata = {{PAD_W{1'b0}}, en_q};
    else                                   bus_rdata = '0;
  end

  assign irq = any_pending(flags_q, en_q);

  AST_OVW_A_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_a_load && flags_q[BIT_CAP_A]) |=> (flags_q[BIT_OVW_A] && flags_q[BIT_CAP_A])); // R6
  AST_OVW_B_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_b_load && flags_q[BIT_CAP_B]) |=> (flags_q[BIT_OVW_B] && flags_q[BIT_CAP_B])); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NFLAG] == '0);                                                       // R3
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags_q != '0 && en_q != '0));                                             // R10
  AST_OTHER_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_flags && !wr_enable && set_vec == '0) |=> ($stable(flags_q) && $stable(en_q))); // R11
endmodule

// File: tb/tmr_irq_flags_test.sv
`timescale 1ns/1ps
module tmr_irq_flags_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_a_hit, cmp_b_hit, cap_a_load, cap_b_load;
  logic [1:0]  bus_addr;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [5:0] m_flags = '0;
  logic [5:0] m_en    = '0;

  always #10 clk = ~clk;

  tmr_irq_flags uut (
    .clk(clk), .rst_n(rst_n),
    .cmp_a_hit(cmp_a_hit), .cmp_b_hit(cmp_b_hit),
    .cap_a_load(cap_a_load), .cap_b_load(cap_b_load),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [15:0] exp_read(input logic [1:0] a);
    if (a == 2'd0) return {10'd0, m_flags};
    if (a == 2'd1) return {10'd0, m_en};
    return 16'd0;
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int i = 0; i < 6; i++) if (m_flags[i] && m_en[i]) r = 1'b1;
    return r;
  endfunction

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input logic [3:0] ev, input logic we,
                            input logic [1:0] a, input logic [15:0] wd);
    logic [5:0] setv;
    logic [5:0] clrv;
    setv = {ev[3] & m_flags[3], ev[2] & m_flags[2], ev};
    clrv = (we && a == 2'd0) ? wd[5:0] : 6'd0;
    m_flags = setv | (m_flags & ~clrv);
    if (we && a == 2'd1) m_en = wd[5:0];
  endtask

  // ev = {cap_b, cap_a, cmp_b, cmp_a}
  task automatic step(input string tag, input logic [3:0] ev, input logic we,
                      input logic [1:0] a, input logic [15:0] wd);
    {cap_b_load, cap_a_load, cmp_b_hit, cmp_a_hit} = ev;
    bus_we = we; bus_addr = a; bus_wdata = wd;
    #1;
    check16({tag, " read"}, bus_rdata, exp_read(a));
    check16({tag, " irq"}, {15'd0, irq}, {15'd0, exp_irq()});
    @(posedge clk);
    model_edge(ev, we, a, wd);
    @(negedge clk);
  endtask

  task automatic expect_rd(input string tag, input logic [1:0] a, input logic [15:0] exp);
    {cap_b_load, cap_a_load, cmp_b_hit, cmp_a_hit} = 4'd0;
    bus_we = 1'b0; bus_addr = a; bus_wdata = 16'd0;
    #1;
    check16(tag, bus_rdata, exp);
    check16({tag, " model"}, bus_rdata, exp_read(a));
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    {cap_b_load, cap_a_load, cmp_b_hit, cmp_a_hit} = 4'd0;
    bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 16'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    expect_rd("R1 flags after reset", 2'd0, 16'h0000);
    expect_rd("R1 enables after reset", 2'd1, 16'h0000);
    check16("R1 irq after reset", {15'd0, irq}, 16'd0);

    step("R4 cmp a", 4'b0001, 1'b0, 2'd0, 16'd0);
    expect_rd("R4 cmp a set bit0", 2'd0, 16'h0001);
    step("R4 cmp b", 4'b0010, 1'b0, 2'd0, 16'd0);
    expect_rd("R2 R4 cmp b set bit1", 2'd0, 16'h0003);
    step("R7 clr bit0", 4'b0000, 1'b1, 2'd0, 16'h0001);
    expect_rd("R7 clear one", 2'd0, 16'h0002);
    step("R7 write zero", 4'b0000, 1'b1, 2'd0, 16'h0000);
    expect_rd("R7 zero keeps", 2'd0, 16'h0002);
    step("R7 clr all", 4'b0000, 1'b1, 2'd0, 16'hFFFF);
    expect_rd("R7 cleared", 2'd0, 16'h0000);

    step("R5 cap a", 4'b0100, 1'b0, 2'd0, 16'd0);
    expect_rd("R5 cap a bit2", 2'd0, 16'h0004);
    step("R6 cap a again", 4'b0100, 1'b0, 2'd0, 16'd0);
    expect_rd("R6 ovw a bit4", 2'd0, 16'h0014);
    step("R5 cap b", 4'b1000, 1'b0, 2'd0, 16'd0);
    expect_rd("R5 cap b bit3", 2'd0, 16'h001C);
    step("R6 cap b with clear", 4'b1000, 1'b1, 2'd0, 16'h0008);
    expect_rd("R6 R8 ovw b despite clear", 2'd0, 16'h003C);

    step("R7 clr all", 4'b0000, 1'b1, 2'd0, 16'h003F);
    step("R8 set vs clr", 4'b0001, 1'b1, 2'd0, 16'h0001);
    expect_rd("R8 set wins", 2'd0, 16'h0001);

    step("R9 en all", 4'b0000, 1'b1, 2'd1, 16'hFFFF);
    expect_rd("R9 R3 enable readback", 2'd1, 16'h003F);
    check16("R10 irq on", {15'd0, irq}, 16'd1);
    step("R9 en bit1", 4'b0000, 1'b1, 2'd1, 16'h0002);
    check16("R10 irq masked", {15'd0, irq}, 16'd0);

    step("R3 rsvd write", 4'b0000, 1'b1, 2'd0, 16'hFFC0);
    expect_rd("R3 rsvd ignored", 2'd0, 16'h0001);

    step("R11 write addr2", 4'b0000, 1'b1, 2'd2, 16'hFFFF);
    step("R11 write addr3", 4'b0000, 1'b1, 2'd3, 16'hFFFF);
    expect_rd("R11 addr2 zero", 2'd2, 16'h0000);
    expect_rd("R11 addr3 zero", 2'd3, 16'h0000);
    expect_rd("R11 enables kept", 2'd1, 16'h0002);
    step("R11 read idle", 4'b0000, 1'b0, 2'd0, 16'd0);
    expect_rd("R11 flags kept", 2'd0, 16'h0001);

    for (int n = 0; n < 3000; n++) begin
      logic [3:0]  ev;
      logic        we;
      logic [1:0]  a;
      logic [15:0] wd;
      for (int b = 0; b < 4; b++) ev[b] = ($urandom_range(0, 3) == 0);
      we = ($urandom_range(0, 2) == 0);
      a  = 2'($urandom_range(0, 3));
      wd = 16'($urandom());
      step("R2 R10 random", ev, we, a, wd);
    end
    expect_rd("R2 random final flags", 2'd0, exp_read(2'd0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule